// File: doc/BRIEF.md
# Clock-Driving Synchronous Serial Receiver

This block is the receive side of a synchronous serial port that produces its own bit clock. A programmable divider sets the bit clock rate. The clock idles low, so the rising edge is the leading edge. The data line is sampled on each falling edge and written into a shift register, least significant bit first. A character is 8 bits long, or 9 bits when the wide-character control is set. Each finished character goes to a downstream receive buffer with a one-cycle strobe.

Two enables start reception. The single-shot enable is set by a one-cycle request pulse. It allows exactly one character and then clears itself. The continuous enable is a level input and keeps characters coming back to back until it is dropped. If both are on, the single-shot enable clears after the first character and reception goes on under the continuous enable. Dropping the continuous enable in the middle of a character stops the clock at once and throws away the bits taken so far. Dropping the port enable resets the whole receiver. While the downstream buffer reports a lock, no new character is started.

Top module: `sync_rx_master`

## Requirements
- R1: After reset, `sclk_o` is low, `push_vld` is low and `single_en_o` is low.
- R2: Each high and each low phase of `sclk_o` inside a transfer lasts `baud_div + 1` system clocks.
- R3: A `single_req` pulse with `cont_en` low produces exactly as many rising edges of `sclk_o` as the character has bits. After that the clock stays low and `single_en_o` returns to 0.
- R4: With `cont_en` high, characters follow each other with no gap in the bit clock timing, until `cont_en` is cleared.
- R5: Clearing `cont_en` partway through a character, while `single_en_o` is 0, forces `sclk_o` low in the next cycle and no character is pushed. The next character starts again from bit 0.
- R6: With both enables on, `single_en_o` clears when the first character is pushed, and reception continues under `cont_en`.
- R7: `rx_din` is sampled at each falling edge of `sclk_o`, and the first bit received lands in `push_data[0]`. With `mode9` = 1 the character has 9 bits, and the ninth bit received is `push_data[8]`. With `mode9` = 0 the character has 8 bits and `push_data[8]` is 0.
- R8: `push_vld` is a one-cycle pulse. It appears in the same cycle that `sclk_o` shows the final falling edge of the character.
- R9: When `port_en` is low, `sclk_o` is low and `single_en_o` is cleared from the next cycle on, and a partial character is dropped.
- R10: While `ovr_lock` is high, no new character starts. A pending single-shot enable waits, and continuous reception stops after the character in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Port enable; low resets the receiver |
| mode9 | input | 1 | 1 selects 9-bit characters |
| baud_div | input | DIV_W | Half-period of the bit clock minus one, in system clocks |
| single_req | input | 1 | One-cycle pulse that sets the single-shot enable |
| cont_en | input | 1 | Continuous receive enable (level) |
| ovr_lock | input | 1 | Buffer lock; blocks the start of new characters |
| rx_din | input | 1 | Serial data in |
| sclk_o | output | 1 | Generated bit clock, idles low |
| single_en_o | output | 1 | Current state of the single-shot enable |
| push_vld | output | 1 | One-cycle strobe for a completed character |
| push_data | output | DATA_W+1 | Completed character, LSB first on the wire |

## Verification
Random 8-bit and 9-bit characters are received in single-shot mode with random divider values. This separates errors in bit order, in the ninth-bit placement and in the half-period count. Back-to-back continuous reception is timed against the ideal number of cycles, which exposes any idle cycle inserted between characters. Directed cases drop `cont_en` or `port_en` while the clock is high, so a truncated character that is wrongly pushed can be told apart from one that is correctly discarded. Holding `ovr_lock` shows the difference between refusing a start and cutting a character already in progress.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  typedef enum logic {RX_IDLE, RX_RUN} rx_state_t;
endpackage

// File: rtl/sync_rx_baud.sv
module sync_rx_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt >= div);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0) |=> (!tick || div == '0)) else $error("tick spacing"); // R2
endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift #(
  parameter int DATA_W = 8,
  localparam int MAXB  = DATA_W + 1,
  localparam int CNT_W = $clog2(MAXB + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            sample,
  input  logic            din,
  input  logic            mode9,
  output logic            done,
  output logic [MAXB-1:0] word_nxt
);
  logic [MAXB-1:0]  sr;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = mode9 ? CNT_W'(MAXB - 1) : CNT_W'(MAXB - 2);
  assign done = sample && (cnt >= last);

  always_comb begin
    word_nxt      = sr;
    word_nxt[cnt] = din;
    if (!mode9) word_nxt[MAXB-1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sr  <= '0;
      cnt <= '0;
    end else if (sample) begin
      if (done) begin
        sr  <= '0;
        cnt <= '0;
      end else begin
        sr  <= word_nxt;
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_BIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MAXB - 1)) else $error("bit count out of range"); // R7
endmodule

// File: rtl/sync_rx_ctrl.sv
module sync_rx_ctrl
  import sync_rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic port_en,
  input  logic single_req,
  input  logic cont_en,
  input  logic ovr_lock,
  input  logic tick,
  input  logic done,
  output logic baud_run,
  output logic sample,
  output logic clr,
  output logic sclk_q,
  output logic single_q
);
  rx_state_t state;
  logic      running;
  logic      abort;

  assign running  = (state == RX_RUN);
  assign abort    = running && !cont_en && !single_q;
  assign baud_run = running && !abort && port_en;
  assign sample   = baud_run && tick && sclk_q;
  assign clr      = !running || abort || !port_en;

  always_ff @(posedge clk) begin
    if (rst || !port_en) begin
      state    <= RX_IDLE;
      sclk_q   <= 1'b0;
      single_q <= 1'b0;
    end else begin
      if (done)       single_q <= 1'b0;
      if (single_req) single_q <= 1'b1;
      case (state)
        RX_IDLE: begin
          sclk_q <= 1'b0;
          if ((single_q || cont_en) && !ovr_lock) state <= RX_RUN;
        end
        default: begin
          if (abort) begin
            state  <= RX_IDLE;
            sclk_q <= 1'b0;
          end else if (tick) begin
            sclk_q <= !sclk_q;
            if (done && (!cont_en || ovr_lock)) state <= RX_IDLE;
          end
        end
      endcase
    end
  end

  AST_ABORT_STOP: assert property (@(posedge clk) disable iff (rst)
    abort |=> !sclk_q) else $error("clock kept after abort"); // R5
  AST_PORT_OFF: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> (!sclk_q && !single_q)) else $error("port off not honoured"); // R9
  AST_LOCK_NOSTART: assert property (@(posedge clk) disable iff (rst)
    (!running && ovr_lock) |=> !running) else $error("start under lock"); // R10
  AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (done && !single_req) |=> !single_q) else $error("single enable stuck"); // R3
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master #(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8,
  localparam int MAXB  = DATA_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             port_en,
  input  logic             mode9,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             single_req,
  input  logic             cont_en,
  input  logic             ovr_lock,
  input  logic             rx_din,
  output logic             sclk_o,
  output logic             single_en_o,
  output logic             push_vld,
  output logic [MAXB-1:0]  push_data
);
  logic            tick, baud_run, sample, clr, done;
  logic [MAXB-1:0] word_nxt;

  sync_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .run(baud_run), .div(baud_div), .tick(tick)
  );

  sync_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .clr(clr), .sample(sample), .din(rx_din),
    .mode9(mode9), .done(done), .word_nxt(word_nxt)
  );

  sync_rx_ctrl u_ctrl (
    .clk(clk), .rst(rst), .port_en(port_en), .single_req(single_req),
    .cont_en(cont_en), .ovr_lock(ovr_lock), .tick(tick), .done(done),
    .baud_run(baud_run), .sample(sample), .clr(clr),
    .sclk_q(sclk_o), .single_q(single_en_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      push_vld  <= 1'b0;
      push_data <= '0;
    end else begin
      push_vld <= done;
      if (done) push_data <= word_nxt;
    end
  end

  AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (rst)
    push_vld |=> !push_vld) else $error("push longer than one cycle"); // R8
endmodule

// File: tb/sync_rx_master_tb.sv
module sync_rx_master_tb;
  localparam int CLK_P = 10;

  logic       clk = 0, rst = 1, port_en = 0, mode9 = 0, single_req = 0;
  logic       cont_en = 0, ovr_lock = 0, rx_din = 0;
  logic [7:0] baud_div = 8'd3;
  logic       sclk_o, single_en_o, push_vld;
  logic [8:0] push_data;

  sync_rx_master u_dut (
    .clk(clk), .rst(rst), .port_en(port_en), .mode9(mode9), .baud_div(baud_div),
    .single_req(single_req), .cont_en(cont_en), .ovr_lock(ovr_lock), .rx_din(rx_din),
    .sclk_o(sclk_o), .single_en_o(single_en_o), .push_vld(push_vld), .push_data(push_data)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [8:0] words [64];
  int widx = 0, bidx = 0, rises = 0, rise_total = 0, pushes = 0, hi_len = 0;
  logic sclk_prev = 0, push_prev = 0, short_ok = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int nbits(input logic m9);
    return m9 ? 9 : 8;
  endfunction

  function automatic logic [8:0] expect_word(input logic [8:0] w, input logic m9);
    return m9 ? w : {1'b0, w[7:0]};
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (sclk_o && !sclk_prev) begin
        rx_din = words[widx][bidx];
        bidx++; rises++; rise_total++; hi_len = 1;
      end else if (sclk_o) hi_len++;
      if (!sclk_o && sclk_prev && !short_ok)
        chk(hi_len == int'(baud_div) + 1, "R2 high phase", hi_len, int'(baud_div) + 1);
      if (push_vld) begin
        chk(!push_prev, "R8 single-cycle strobe", push_prev, 0);
        chk(sclk_prev && !sclk_o, "R8 strobe on last fall", {sclk_prev, sclk_o}, 2);
        chk(rises == nbits(mode9), "R3 clock count", rises, nbits(mode9));
        chk(push_data == expect_word(words[widx], mode9), "R7 data", push_data,
            expect_word(words[widx], mode9));
        widx = (widx + 1) % 64; bidx = 0; rises = 0; pushes++;
      end else if (!port_en || (!cont_en && !single_en_o)) begin
        bidx = 0; rises = 0;
      end
      sclk_prev = sclk_o; push_prev = push_vld;
    end
  end

  task automatic report;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..all act=timeout exp=done");
    report();
  end

  task automatic pulse_single;
    @(negedge clk); single_req = 1;
    @(negedge clk); single_req = 0;
  endtask

  task automatic wait_push(input int target);
    for (int i = 0; i < 20000 && pushes < target; i++) @(negedge clk);
  endtask

  task automatic wait_rises(input int target);
    for (int i = 0; i < 20000 && rise_total < target; i++) @(negedge clk);
  endtask

  initial begin
    int base, rt, t0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) words[i] = 9'($urandom);
    repeat (4) @(negedge clk);
    rst = 0; port_en = 1;
    @(negedge clk);
    chk(!sclk_o && !push_vld && !single_en_o, "R1 reset state",
        {sclk_o, push_vld, single_en_o}, 0);

    // R3 single 8-bit character
    baud_div = 2; mode9 = 0; base = pushes;
    pulse_single(); wait_push(base + 1);
    chk(pushes == base + 1, "R3 single push", pushes, base + 1);
    rt = rise_total; repeat (40) @(negedge clk);
    chk(rise_total == rt, "R3 clock stops", rise_total, rt);
    chk(!single_en_o, "R3 self clear", single_en_o, 0);

    // R7 single 9-bit, fastest divider
    baud_div = 0; mode9 = 1; base = pushes;
    pulse_single(); wait_push(base + 1);
    chk(pushes == base + 1, "R7 nine-bit push", pushes, base + 1);

    // R4 continuous back-to-back, then R5 abort
    baud_div = 1; mode9 = 0; base = pushes;
    @(negedge clk); cont_en = 1; t0 = 0;
    for (int i = 0; i < 20000 && pushes < base + 3; i++) begin @(negedge clk); t0++; end
    chk(pushes == base + 3, "R4 three chars", pushes, base + 3);
    chk(t0 <= 3 * 8 * 2 * 2 + 4, "R4 no gap", t0, 3 * 8 * 2 * 2 + 4);
    wait_rises(rise_total + 3);
    short_ok = 1; cont_en = 0;
    @(negedge clk);
    chk(!sclk_o, "R5 clock stops at once", sclk_o, 0);
    rt = rise_total; repeat (30) @(negedge clk);
    chk(pushes == base + 3, "R5 partial discarded", pushes, base + 3);
    chk(rise_total == rt, "R5 stays idle", rise_total, rt);
    short_ok = 0;
    pulse_single(); wait_push(base + 4);
    chk(pushes == base + 4, "R5 fresh start", pushes, base + 4);

    // R6 both enables
    baud_div = 1; base = pushes;
    @(negedge clk); cont_en = 1; single_req = 1;
    @(negedge clk); single_req = 0;
    wait_push(base + 1);
    chk(!single_en_o, "R6 single cleared", single_en_o, 0);
    wait_push(base + 2);
    chk(pushes == base + 2, "R6 continues", pushes, base + 2);
    short_ok = 1; cont_en = 0; repeat (10) @(negedge clk); short_ok = 0;

    // R10 lock holds a pending single
    ovr_lock = 1; base = pushes; rt = rise_total;
    pulse_single(); repeat (60) @(negedge clk);
    chk(rise_total == rt, "R10 no start", rise_total, rt);
    chk(single_en_o, "R10 pending kept", single_en_o, 1);
    ovr_lock = 0; wait_push(base + 1);
    chk(pushes == base + 1, "R10 start after release", pushes, base + 1);

    // R10 lock during continuous
    base = pushes; @(negedge clk); cont_en = 1;
    wait_push(base + 1); wait_rises(rise_total + 1);
    ovr_lock = 1; wait_push(base + 2);
    chk(pushes == base + 2, "R10 current char completes", pushes, base + 2);
    rt = rise_total; repeat (60) @(negedge clk);
    chk(rise_total == rt, "R10 continuous halts", rise_total, rt);
    cont_en = 0; ovr_lock = 0; @(negedge clk);

    // R9 port disable mid-character
    baud_div = 2; base = pushes;
    pulse_single(); wait_rises(rise_total + 3);
    short_ok = 1; port_en = 0;
    @(negedge clk);
    chk(!sclk_o && !single_en_o, "R9 port off", {sclk_o, single_en_o}, 0);
    repeat (40) @(negedge clk);
    chk(pushes == base, "R9 no push", pushes, base);
    port_en = 1; repeat (10) @(negedge clk);
    chk(!sclk_o && !single_en_o, "R9 no restart", {sclk_o, single_en_o}, 0);
    short_ok = 0;

    // R7 random single characters
    for (int k = 0; k < 24; k++) begin
      baud_div = 8'($urandom % 6); mode9 = 1'($urandom % 2); base = pushes;
      pulse_single(); wait_push(base + 1);
      chk(pushes == base + 1, "R7 random char", pushes, base + 1);
      repeat (3) @(negedge clk);
    end
    report();
  end
endmodule